// File: doc/BRIEF.md
# Pipelined Burst SRAM with Load/Advance Control

This block is a clocked single-port memory with a 36-bit word made of four 9-bit byte lanes. Every control input is sampled on the rising clock edge, and only when the active-low clock enable is low. Three chip selects, all of which must be in their active state, qualify the start of an access. One control line picks between loading a fresh external address and stepping a 2-bit burst counter. The counter steps the low two address bits while the upper bits stay fixed.

The pipeline needs no idle cycle between a read and a write. Write data is taken from `din` on the second enabled edge after its address. Read data appears on `dout` after the second enabled edge following its address. A read placed right behind a write to the same word returns the new bytes. When the clock enable is held high, the whole pipeline freezes and the previous cycle is stretched. The data bus is split into `din`, `dout` and a drive flag `q_drive`. The drive flag follows the asynchronous active-low output enable, but only while the output slot holds read data.

The depth is set by `ADDR_W`: 17 gives the full 128K words, and the default is kept small for simulation.

Top module: `burst_sram`

## Requirements
- R1: An access starts only on an enabled edge with `load_n`=0, `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A load with any select inactive deselects the block, and `q_drive` stays low for the slot that load would have filled.
- R2: On a rising edge with `clk_en_n`=1, no state changes: `dout` and the output slot hold their values.
- R3: For a read whose address is sampled on enabled edge N, `dout` shows the word after enabled edge N+2, and the slot is marked as read.
- R4: For a write sampled on enabled edge N, `din` is sampled on enabled edge N+2. Lane i (bits 9i+8..9i) is written only when `lane_wr_n[i]`=0 on edge N, and the other lanes keep their contents.
- R5: With `ILV`=0, each enabled edge with `load_n`=1 during a burst steps the low address bits linearly (start+1, +2, +3, modulo 4), while bits `ADDR_W-1..2` stay those of the load.
- R6: With `ILV`=1, the k-th step of a burst uses low bits start XOR k.
- R7: After a deselect, enabled edges with `load_n`=1 start no access, whatever the chip selects show.
- R8: `q_drive` is low whenever `out_en_n` is high, and it follows `out_en_n` without waiting for a clock edge.
- R9: `q_drive` is low after any edge at which the output slot received a write or no access, including the first slot after a deselect.
- R10: A read placed directly behind a write, or any later read, to the same word returns the bytes that write stored.
- R11: A synchronous high `rst` clears the pipeline, so `q_drive` stays low until the first selected read reaches the output.
- R12: The read/write type of a burst is fixed on its load edge, and `wr_n` on advance edges is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Low: load address and start access; high: advance burst |
| wr_n | input | 1 | Write enable, active low, sampled on load edges |
| lane_wr_n | input | 4 | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| dout | output | 36 | Registered read data |
| q_drive | output | 1 | High when `dout` should drive the bus |

## Verification
A write can commit to memory on the same edge that the block RAM samples the word for the next read. This is where the forwarding path and the memory array meet. The bench provokes it with write-then-read pairs to one address, with partial lane masks, both directed and random. The returned word is judged lane by lane against a bench memory that applies writes in order. Random freezes of the clock enable are mixed in, so a stretched cycle can also fall across that collision.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // low address bits for burst step k from the start offset
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    return ilv ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter bit ILV    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              sel,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              burst_on,
  output logic              a_vld,
  output logic              a_wr,
  output logic [ADDR_W-1:0] a_addr,
  output logic [LANES-1:0]  a_be
);
  localparam int HI_W = ADDR_W - 2;

  logic            burst_wr;
  logic [HI_W-1:0] base_hi;
  logic [1:0]      start;
  logic [1:0]      step_q;
  logic [1:0]      step_nx;

  assign step_nx = step_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on <= 1'b0;
      burst_wr <= 1'b0;
      base_hi  <= '0;
      start    <= '0;
      step_q   <= '0;
      a_vld    <= 1'b0;
      a_wr     <= 1'b0;
      a_addr   <= '0;
      a_be     <= '0;
    end else if (ce) begin
      a_be <= ~lane_wr_n;
      if (!load_n) begin
        burst_on <= sel;
        a_vld    <= sel;
        if (sel) begin
          burst_wr <= ~wr_n;
          a_wr     <= ~wr_n;
          base_hi  <= addr[ADDR_W-1:2];
          start    <= addr[1:0];
          step_q   <= 2'd0;
          a_addr   <= addr;
        end
      end else if (burst_on) begin
        step_q <= step_nx;
        a_vld  <= 1'b1;
        a_wr   <= burst_wr;
        a_addr <= {base_hi, burst_off(start, step_nx, ILV)};
      end else begin
        a_vld <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              ce,
  input  logic              w_en,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [LANES-1:0]  w_be,
  input  logic [WORD_W-1:0] w_data,
  input  logic [ADDR_W-1:0] r_addr,
  output logic [WORD_W-1:0] r_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // simple dual-port, read-before-write, lane-masked
  always_ff @(posedge clk) begin
    if (ce) begin
      if (w_en) begin
        for (int i = 0; i < LANES; i++) begin
          if (w_be[i]) mem[w_addr][i*LANE_W +: LANE_W] <= w_data[i*LANE_W +: LANE_W];
        end
      end
      r_data <= mem[r_addr];
    end
  end
endmodule

// File: rtl/burst_sram_out.sv
module burst_sram_out
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              a_vld,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic [WORD_W-1:0] din,
  input  logic [WORD_W-1:0] r_data,
  input  logic              out_en_n,
  output logic              b_vld,
  output logic              b_wr,
  output logic              w_en,
  output logic [ADDR_W-1:0] w_addr,
  output logic [LANES-1:0]  w_be,
  output logic [WORD_W-1:0] dout,
  output logic              slot_rd,
  output logic              q_drive
);
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_be;
  logic              fw_vld;
  logic [ADDR_W-1:0] fw_addr;
  logic [LANES-1:0]  fw_be;
  logic [WORD_W-1:0] fw_data;
  logic              fw_hit;
  logic [WORD_W-1:0] merged;

  assign w_en   = b_vld & b_wr;
  assign w_addr = b_addr;
  assign w_be   = b_be;
  assign fw_hit = fw_vld && (fw_addr == b_addr);

  // lanes of the last committed write override the early memory read
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (fw_hit && fw_be[g]) ? fw_data[g*LANE_W +: LANE_W]
                                                              : r_data[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_vld   <= 1'b0;
      b_wr    <= 1'b0;
      b_addr  <= '0;
      b_be    <= '0;
      fw_vld  <= 1'b0;
      fw_addr <= '0;
      fw_be   <= '0;
      fw_data <= '0;
      slot_rd <= 1'b0;
      dout    <= '0;
    end else if (ce) begin
      b_vld  <= a_vld;
      b_wr   <= a_wr;
      b_addr <= a_addr;
      b_be   <= a_be;
      if (w_en) begin
        fw_vld  <= 1'b1;
        fw_addr <= b_addr;
        fw_be   <= b_be;
        fw_data <= din;
      end
      slot_rd <= b_vld & ~b_wr;
      if (b_vld && !b_wr) dout <= merged;
    end
  end

  assign q_drive = slot_rd & ~out_en_n;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter bit ILV    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              cs_c_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [3:0]        lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       din,
  input  logic              out_en_n,
  output logic [35:0]       dout,
  output logic              q_drive
);
  logic              ce;
  logic              sel;
  logic              burst_on;
  logic              a_vld;
  logic              a_wr;
  logic [ADDR_W-1:0] a_addr;
  logic [LANES-1:0]  a_be;
  logic              b_vld;
  logic              b_wr;
  logic              w_en;
  logic [ADDR_W-1:0] w_addr;
  logic [LANES-1:0]  w_be;
  logic [WORD_W-1:0] r_data;
  logic              slot_rd;

  assign ce  = ~clk_en_n;
  assign sel = ~cs_a_n & cs_b & ~cs_c_n;

  burst_sram_addr #(.ADDR_W(ADDR_W), .ILV(ILV)) u_addr (
    .clk(clk), .rst(rst), .ce(ce), .sel(sel), .load_n(load_n), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .addr(addr), .burst_on(burst_on), .a_vld(a_vld),
    .a_wr(a_wr), .a_addr(a_addr), .a_be(a_be)
  );

  burst_sram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .ce(ce), .w_en(w_en), .w_addr(w_addr), .w_be(w_be),
    .w_data(din), .r_addr(a_addr), .r_data(r_data)
  );

  burst_sram_out #(.ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst(rst), .ce(ce), .a_vld(a_vld), .a_wr(a_wr), .a_addr(a_addr),
    .a_be(a_be), .din(din), .r_data(r_data), .out_en_n(out_en_n),
    .b_vld(b_vld), .b_wr(b_wr), .w_en(w_en), .w_addr(w_addr), .w_be(w_be),
    .dout(dout), .slot_rd(slot_rd), .q_drive(q_drive)
  );
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              load_n,
  input logic              cs_a_n,
  input logic              cs_b,
  input logic              cs_c_n,
  input logic              burst_on,
  input logic              a_vld,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_vld,
  input logic              b_wr,
  input logic              slot_rd,
  input logic [35:0]       dout
);
  p_desel_r1: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && !(!cs_a_n && cs_b && !cs_c_n)) |=> !a_vld);

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !load_n && !cs_a_n && cs_b && !cs_c_n) |=> a_vld);

  p_freeze_r2: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(dout) && $stable(slot_rd)));

  p_read_slot_r3: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && b_vld && !b_wr) |=> slot_rd);

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n && burst_on) |=> (a_addr[ADDR_W-1:2] == $past(a_addr[ADDR_W-1:2])));

  p_no_adv_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && load_n && !burst_on) |=> !a_vld);

  p_write_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !(b_vld && !b_wr)) |=> !slot_rd);
endmodule

bind burst_sram burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .load_n(load_n), .cs_a_n(cs_a_n),
  .cs_b(cs_b), .cs_c_n(cs_c_n), .burst_on(burst_on), .a_vld(a_vld), .a_addr(a_addr),
  .b_vld(b_vld), .b_wr(b_wr), .slot_rd(slot_rd), .dout(dout)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/100ps
module burst_sram_tb;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst, clk_en_n, cs_a_n, cs_b, cs_c_n, load_n, wr_n, out_en_n;
  logic [3:0]  lane_wr_n;
  logic [AW-1:0] addr;
  logic [35:0] din, dout, dout_ilv;
  logic q_drive, drv_ilv;

  always #2.5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .ILV(1'b0)) u_dut (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .din(din), .out_en_n(out_en_n), .dout(dout), .q_drive(q_drive));

  burst_sram #(.ADDR_W(AW), .ILV(1'b1)) u_dut_ilv (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .din(din), .out_en_n(out_en_n), .dout(dout_ilv), .q_drive(drv_ilv));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R11";

  // bench model
  logic [35:0]   mem_m [256];
  logic          m_act, m_w;
  logic [AW-1:0] m_base;
  logic [1:0]    m_k;
  logic          h1_v, h1_w, h2_v, h2_w;
  logic [AW-1:0] h1_a, h2_a;
  logic [3:0]    h1_be, h2_be;
  logic          exp_rd;
  logic [35:0]   exp_dout;

  task automatic chk(input string rq, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic logic [35:0] apply_lanes(input logic [35:0] old, input logic [35:0] nw,
                                              input logic [3:0] be);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic tick();
    logic held, sel, nv, nw;
    logic [AW-1:0] na;
    @(posedge clk);
    held = clk_en_n;
    if (rst) begin
      h1_v = 0; h2_v = 0; m_act = 0; exp_rd = 0; exp_dout = '0;
    end else if (!clk_en_n) begin
      if (h2_v && h2_w) mem_m[h2_a] = apply_lanes(mem_m[h2_a], din, h2_be);
      exp_rd = h2_v && !h2_w;
      if (exp_rd) exp_dout = mem_m[h2_a];
      sel = !cs_a_n && cs_b && !cs_c_n;
      nv = 0; nw = 0; na = '0;
      if (!load_n) begin
        m_act = sel;
        if (sel) begin m_w = !wr_n; m_base = addr; m_k = 0; nv = 1; nw = !wr_n; na = addr; end
      end else if (m_act) begin
        m_k = m_k + 2'd1; nv = 1; nw = m_w;
        na = {m_base[AW-1:2], 2'(m_base[1:0] + m_k)};
      end
      h2_v = h1_v; h2_w = h1_w; h2_a = h1_a; h2_be = h1_be;
      h1_v = nv; h1_w = nw; h1_a = na; h1_be = ~lane_wr_n;
    end
    #1;
    chk(held ? "R2" : tag, {35'd0, q_drive}, {35'd0, exp_rd && !out_en_n});
    if (exp_rd || held) chk(held ? "R2" : (tag == "R11" ? "R3" : tag), dout, exp_dout);
    @(negedge clk);
  endtask

  task automatic op(input logic ld_n, input logic w_n, input logic [AW-1:0] a, input logic [3:0] bw);
    clk_en_n = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0;
    load_n = ld_n; wr_n = w_n; addr = a; lane_wr_n = bw;
    din = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    tick();
  endtask

  task automatic idle();
    clk_en_n = 0; cs_a_n = 0; cs_b = 0; cs_c_n = 0; load_n = 0; wr_n = 1;
    din = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
    tick();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    rst = 1; clk_en_n = 0; cs_a_n = 0; cs_b = 1; cs_c_n = 0; load_n = 1; wr_n = 1;
    lane_wr_n = 4'h0; addr = '0; din = '0; out_en_n = 0;
    exp_rd = 0; exp_dout = '0; h1_v = 0; h2_v = 0; m_act = 0; m_w = 0; m_base = '0; m_k = 0;
    @(negedge clk);
    // R11: reset state and after release with no read
    tick(); tick(); tick();
    rst = 0;
    tag = "R11"; idle(); idle();

    // R4: fill words 0..63, full lanes
    tag = "R4";
    for (int i = 0; i < 64; i++) op(0, 0, AW'(i), 4'h0);
    idle(); idle();

    // R5 on the linear instance, R6 on the interleaved one
    tag = "R5";
    for (int j = 0; j < 6; j++) begin
      if (j == 0) op(0, 1, 8'd9, 4'hF);
      else if (j < 4) op(1, 1, 8'd0, 4'hF);
      else idle();
      if (j >= 2) chk("R6", dout_ilv, mem_m[{6'd2, 2'd1 ^ 2'(j - 2)}]);
    end
    op(0, 1, 8'd6, 4'hF); op(1, 1, 8'd0, 4'hF); op(1, 1, 8'd0, 4'hF); op(1, 1, 8'd0, 4'hF);
    idle(); idle();

    // R1: each select inactive in turn
    tag = "R1";
    clk_en_n = 0; load_n = 0; wr_n = 1; addr = 8'd3;
    cs_a_n = 1; cs_b = 1; cs_c_n = 0; tick();
    cs_a_n = 0; cs_b = 0; cs_c_n = 0; tick();
    cs_a_n = 0; cs_b = 1; cs_c_n = 1; tick();
    idle(); idle();

    // R7: advance after deselect starts nothing
    tag = "R7";
    idle(); op(1, 1, 8'd5, 4'hF); op(1, 0, 8'd5, 4'hF); op(1, 1, 8'd5, 4'hF);
    idle(); idle();

    // R4: partial lane write, lanes 0 and 2 only
    tag = "R4";
    op(0, 0, 8'd20, 4'b1010); idle(); idle(); op(0, 1, 8'd20, 4'hF); idle(); idle();

    // R10: read directly behind write to same word
    tag = "R10";
    op(0, 0, 8'd30, 4'h0); op(0, 1, 8'd30, 4'hF);
    op(0, 0, 8'd31, 4'b1001); op(0, 1, 8'd31, 4'hF); op(0, 1, 8'd31, 4'hF);
    idle(); idle();

    // R12: wr_n low on advance edges is ignored
    tag = "R12";
    op(0, 1, 8'd40, 4'h0); op(1, 0, 8'd0, 4'h0); op(1, 0, 8'd0, 4'h0); op(1, 0, 8'd0, 4'h0);
    idle(); idle(); op(0, 1, 8'd41, 4'hF); idle(); idle();

    // R8: output enable high blocks drive, and acts without a clock edge
    tag = "R8";
    op(0, 1, 8'd44, 4'hF); op(1, 1, 8'd0, 4'hF);
    out_en_n = 1; op(1, 1, 8'd0, 4'hF);
    out_en_n = 0; op(1, 1, 8'd0, 4'hF);
    out_en_n = 1; #0.2; chk("R8", {35'd0, q_drive}, 36'd0);
    out_en_n = 0; #0.2; chk("R8", {35'd0, q_drive}, {35'd0, exp_rd});
    idle(); idle();

    // R9: write burst and read/write alternation with output enable low
    tag = "R9";
    op(0, 0, 8'd48, 4'h0); op(1, 1, 8'd0, 4'h0); op(1, 1, 8'd0, 4'h5); op(1, 1, 8'd0, 4'h0);
    op(0, 1, 8'd49, 4'hF); op(0, 0, 8'd50, 4'h3); op(0, 1, 8'd50, 4'hF);
    idle(); idle();

    // R2: freeze during a burst
    tag = "R2";
    op(0, 1, 8'd12, 4'hF); op(1, 1, 8'd0, 4'hF);
    clk_en_n = 1; tick(); tick();
    op(1, 1, 8'd0, 4'hF);
    clk_en_n = 1; tick();
    op(1, 1, 8'd0, 4'hF);
    clk_en_n = 1; tick();
    idle(); idle();

    // R3 with R10 and R2 mixed in: random traffic
    tag = "R3";
    for (int n = 0; n < 4000; n++) begin
      clk_en_n = ($urandom % 12 == 0);
      load_n = ($urandom % 3 == 0);
      cs_a_n = ($urandom % 16 == 0);
      cs_b = ($urandom % 16 != 0);
      cs_c_n = ($urandom % 16 == 0);
      wr_n = $urandom % 2;
      lane_wr_n = 4'($urandom);
      addr = AW'($urandom % 64);
      out_en_n = ($urandom % 8 == 0);
      din = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      tick();
    end
    out_en_n = 0; idle(); idle();

    done = 1;
    summary();
    $finish;
  end
endmodule